// File: doc/BRIEF.md
# Sixteen-Source Rotating Priority Interrupt Resolver

This block takes sixteen interrupt request positions and reduces them to one request line for a processor, together with an 8-bit vector byte that names the winning position. For each position it keeps an in-service bit, and arbitration weighs that bit against new requests. The bit is set by an acknowledge, cleared by a return, and software can also set or clear it directly.

Priority is circular. A top-position register picks the position that holds level 0. The other positions follow in ascending circular order, so position p holds level (p - top) mod 16. There are two schemes. In fixed mode, service is fully nested: an in-service position blocks requests of its own level and of every lower level, while higher-level requests still reach the processor. In rotation mode there is no nesting. Each time service completes, the completed position falls to the lowest level and the position after it becomes the top. This gives equal long-run priority to all sources. Request capture, register decode and the processor's own enable flag are handled outside this block.

Top module: `irq_resolver`

## Requirements
- R1: After reset the request line is low, the vector byte is 0x00, every in-service bit is 0 and the top position is 0, so position 0 holds level 0.
- R2: A position wins only if its pending bit is 1 and its mask bit is 0 (mask bit 1 means masked). When no position qualifies, the request line is low.
- R3: Position p holds level (p - top) mod 16, with level 0 the highest. Among the qualifying positions, the one with the smallest level wins.
- R4: When the top-write strobe is high on a clock edge, the top position is loaded with the 4-bit top value. This works in either mode and takes precedence over rotation.
- R5: In fixed mode (mode input 1), the request line is high when a winner exists and either no in-service bit is set or the winner's level is strictly smaller than the smallest level among the in-service positions.
- R6: In rotation mode (mode input 0), any set in-service bit holds the request line low.
- R7: An acknowledge taken while the request line is high sets the winner's in-service bit. From the next cycle the vector byte reads {base[3:0], winner[3:0]}, with the base in bits 7:4 and the position in bits 3:0. At all other times the vector byte holds its value, and an acknowledge taken while the line is low changes nothing.
- R8: A return clears the in-service bit with the smallest level. A return while no in-service bit is set has no effect.
- R9: In rotation mode, when in-service bits clear (by return or software clear), the new top is (c + 1) mod 16, where c is the cleared position with the smallest level. In fixed mode the top does not change on completion.
- R10: When acknowledge and return arrive in the same cycle, the return is applied first and then the winner's bit is set. The winner is the one decided before that edge.
- R11: The per-position software set and clear inputs act on the in-service bits at the clock edge. Where both are high for the same bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Pending request per position |
| mask_i | input | 16 | Mask per position, 1 = masked |
| fixed_mode_i | input | 1 | 1 = fixed nested, 0 = rotation |
| top_we_i | input | 1 | Load strobe for the top position |
| top_i | input | 4 | New top position |
| vec_base_i | input | 4 | Base placed in vector bits 7:4 |
| ack_i | input | 1 | Acknowledge strobe |
| ret_i | input | 1 | Return-from-service strobe |
| isr_set_i | input | 16 | Software set of in-service bits |
| isr_clr_i | input | 16 | Software clear of in-service bits |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Registered vector byte |
| isr_o | output | 16 | In-service vector, readable by software |

## Verification
A corrupted top register shows up at the next acknowledge as a wrong position nibble in the vector. In rotation mode the error also breaks the expected 0,1,2,... service order within one pass of sixteen completions. A wrong in-service bit shows on the request line in the same cycle. It appears either as a spurious preemption in fixed mode or as a request let through while service is still in progress in rotation mode. It is also visible directly on the in-service output one cycle after the faulty edge. A vector that changes without an acknowledge is caught in the first cycle it drifts.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    typedef enum logic {
        PRIO_ROTATE = 1'b0,
        PRIO_FIXED  = 1'b1
    } prio_mode_e;

endpackage

// File: rtl/irq_circ_scan.sv
// Finds the first set bit of vec_i scanning upward from start_i with
// wrap-around. Reports the position and its distance (level) from start.
module irq_circ_scan #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] start_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [IW-1:0] lvl_o
);

    logic [N-1:0] rot;

    // rot[g] is the bit that sits g levels below the start position
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [IW-1:0] src;
        assign src    = IW'(g) + start_i;
        assign rot[g] = vec_i[src];
    end

    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found_o = 1'b1;
                lvl_o   = IW'(k);
            end
        end
        idx_o = lvl_o + start_i;
    end

endmodule

// File: rtl/irq_gate.sv
// Decides whether the best eligible request may be raised to the processor.
module irq_gate #(
    parameter int IW = 4
) (
    input  logic                      mode_i,
    input  logic                      win_found_i,
    input  logic [IW-1:0]             win_lvl_i,
    input  logic                      srv_found_i,
    input  logic [IW-1:0]             srv_lvl_i,
    output logic                      irq_o
);
    import irq_res_pkg::*;

    always_comb begin
        irq_o = 1'b0;
        if (win_found_i) begin
            if (!srv_found_i) begin
                irq_o = 1'b1;
            end else if (prio_mode_e'(mode_i) == PRIO_FIXED) begin
                irq_o = (win_lvl_i < srv_lvl_i);
            end
        end
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int NPOS = 16,
    parameter int VECW = 8,
    localparam int IW    = $clog2(NPOS),
    localparam int BASEW = VECW - IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPOS-1:0]   pend_i,
    input  logic [NPOS-1:0]   mask_i,
    input  logic              fixed_mode_i,
    input  logic              top_we_i,
    input  logic [IW-1:0]     top_i,
    input  logic [BASEW-1:0]  vec_base_i,
    input  logic              ack_i,
    input  logic              ret_i,
    input  logic [NPOS-1:0]   isr_set_i,
    input  logic [NPOS-1:0]   isr_clr_i,
    output logic              irq_o,
    output logic [VECW-1:0]   vector_o,
    output logic [NPOS-1:0]   isr_o
);
    import irq_res_pkg::*;

    typedef struct packed {
        logic [NPOS-1:0] isr;
        logic [IW-1:0]   top;
        logic [VECW-1:0] vec;
    } res_state_t;

    res_state_t st_d, st_q;

    logic [NPOS-1:0] elig;
    logic            win_found, srv_found, cmp_found;
    logic [IW-1:0]   win_idx, win_lvl, srv_idx, srv_lvl, cmp_idx, cmp_lvl;
    logic            irq;
    logic [NPOS-1:0] ret_clr_d, ack_set_d, isr_kept_d, completed_d;
    logic            ack_take_d;

    assign elig = pend_i & ~mask_i;

    irq_circ_scan #(.N(NPOS), .IW(IW)) u_win_scan (
        .vec_i   (elig),
        .start_i (st_q.top),
        .found_o (win_found),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    irq_circ_scan #(.N(NPOS), .IW(IW)) u_srv_scan (
        .vec_i   (st_q.isr),
        .start_i (st_q.top),
        .found_o (srv_found),
        .idx_o   (srv_idx),
        .lvl_o   (srv_lvl)
    );

    irq_gate #(.IW(IW)) u_gate (
        .mode_i      (fixed_mode_i),
        .win_found_i (win_found),
        .win_lvl_i   (win_lvl),
        .srv_found_i (srv_found),
        .srv_lvl_i   (srv_lvl),
        .irq_o       (irq)
    );

    // Clear side of the in-service update: return first, then software clear
    always_comb begin
        ret_clr_d = '0;
        if (ret_i && srv_found) begin
            ret_clr_d[srv_idx] = 1'b1;
        end
        isr_kept_d  = st_q.isr & ~ret_clr_d & ~isr_clr_i;
        completed_d = st_q.isr & ~isr_kept_d;
    end

    irq_circ_scan #(.N(NPOS), .IW(IW)) u_cmp_scan (
        .vec_i   (completed_d),
        .start_i (st_q.top),
        .found_o (cmp_found),
        .idx_o   (cmp_idx),
        .lvl_o   (cmp_lvl)
    );

    always_comb begin
        st_d       = st_q;
        ack_take_d = ack_i && irq;
        ack_set_d  = '0;
        if (ack_take_d) begin
            ack_set_d[win_idx] = 1'b1;
            st_d.vec           = {vec_base_i, win_idx};
        end
        st_d.isr = isr_kept_d | isr_set_i | ack_set_d;
        if (top_we_i) begin
            st_d.top = top_i;
        end else if (prio_mode_e'(fixed_mode_i) == PRIO_ROTATE && cmp_found) begin
            st_d.top = cmp_idx + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = irq;
    assign vector_o = st_q.vec;
    assign isr_o    = st_q.isr;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int NPOS = 16,
    parameter int VECW = 8,
    localparam int IW    = $clog2(NPOS),
    localparam int BASEW = VECW - IW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPOS-1:0]   pend_i,
    input logic [NPOS-1:0]   mask_i,
    input logic              fixed_mode_i,
    input logic              ack_i,
    input logic              ret_i,
    input logic [NPOS-1:0]   isr_set_i,
    input logic [NPOS-1:0]   isr_clr_i,
    input logic              irq_o,
    input logic [VECW-1:0]   vector_o,
    input logic [NPOS-1:0]   isr_o
);

    assert_irq_needs_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(pend_i & ~mask_i)));

    assert_rotate_no_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !fixed_mode_i) |-> (isr_o == '0));

    assert_vector_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(vector_o));

    assert_ack_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && isr_clr_i == '0) |=> isr_o[vector_o[IW-1:0]]);

    assert_ret_clears_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !ack_i && isr_set_i == '0 && isr_clr_i == '0 && isr_o != '0)
        |=> ($countones(isr_o) + 1 == $countones($past(isr_o))));

endmodule

bind irq_resolver irq_resolver_chk #(.NPOS(NPOS), .VECW(VECW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (pend_i),
    .mask_i       (mask_i),
    .fixed_mode_i (fixed_mode_i),
    .ack_i        (ack_i),
    .ret_i        (ret_i),
    .isr_set_i    (isr_set_i),
    .isr_clr_i    (isr_clr_i),
    .irq_o        (irq_o),
    .vector_o     (vector_o),
    .isr_o        (isr_o)
);

// File: tb/sim_irq_resolver.sv
`timescale 1ns/1ps
module sim_irq_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pend = '0, mask = '0, sset = '0, sclr = '0;
    logic        fixed = 1'b0, twe = 1'b0, ack = 1'b0, ret = 1'b0;
    logic [3:0]  tval = '0, base = 4'hA;
    logic        irq;
    logic [7:0]  vec;
    logic [15:0] isr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] m_isr = '0;
    int          m_top = 0;
    logic [7:0]  m_vec = '0;

    always #4 clk = ~clk;

    irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask),
        .fixed_mode_i(fixed), .top_we_i(twe), .top_i(tval), .vec_base_i(base),
        .ack_i(ack), .ret_i(ret), .isr_set_i(sset), .isr_clr_i(sclr),
        .irq_o(irq), .vector_o(vec), .isr_o(isr)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int best(logic [15:0] v, int t);
        for (int k = 0; k < 16; k++) begin
            if (v[(t + k) % 16]) return (t + k) % 16;
        end
        return -1;
    endfunction

    function automatic int lvl(int p, int t);
        return (p - t + 16) % 16;
    endfunction

    function automatic bit exp_irq();
        int w, s;
        w = best(pend & ~mask, m_top);
        s = best(m_isr, m_top);
        if (w < 0) return 0;
        if (s < 0) return 1;
        if (!fixed) return 0;
        return lvl(w, m_top) < lvl(s, m_top);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic look(string tag);
        #1;
        chk({tag, " irq"}, 32'(irq), 32'(exp_irq()));
        chk({tag, " isr"}, 32'(isr), 32'(m_isr));
        chk({tag, " vec"}, 32'(vec), 32'(m_vec));
    endtask

    task automatic cyc(bit a, bit r);
        bit ei;
        int w, s;
        ei = exp_irq();
        w  = best(pend & ~mask, m_top);
        s  = best(m_isr, m_top);
        ack = a; ret = r;
        step();
        ack = 0; ret = 0;
        if (r && s >= 0) begin
            m_isr[s] = 1'b0;
            if (!fixed) m_top = (s + 1) % 16;
        end
        if (a && ei) begin
            m_isr[w] = 1'b1;
            m_vec    = {base, 4'(w)};
        end
    endtask

    task automatic set_top(int t);
        twe = 1; tval = 4'(t);
        step();
        twe = 0;
        m_top = t;
    endtask

    task automatic sw(logic [15:0] s, logic [15:0] c);
        logic [15:0] kept, comp;
        sset = s; sclr = c;
        step();
        sset = '0; sclr = '0;
        kept = m_isr & ~c;
        comp = m_isr & ~kept;
        m_isr = kept | s;
        if (!fixed && comp != 0) m_top = (best(comp, m_top) + 1) % 16;
    endtask

    task automatic drain();
        while (m_isr != 0) cyc(0, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        look("R1 reset");
        pend = 16'h0001; #1;
        chk("R1 top is 0", 32'(irq), 32'd1);
        cyc(1, 0);
        chk("R1 pos0 wins", 32'(vec), 32'hA0);
        cyc(0, 1);
        pend = '0;

        // R3/R7/R8: fixed mode, every top and every single source
        fixed = 1;
        for (int t = 0; t < 16; t++) begin
            set_top(t);
            base = 4'(t);
            for (int p = 0; p < 16; p++) begin
                pend = 16'(1) << p;
                look("R3 single");
                cyc(1, 0);
                look("R7 ack vec");
                cyc(0, 1);
                look("R8 ret");
            end
        end
        pend = '0;
        cyc(0, 1);
        look("R8 ret idle");
        cyc(1, 0);
        look("R7 ack idle");

        // R3: all pairs for two tops
        for (int ti = 0; ti < 2; ti++) begin
            set_top(ti * 7);
            for (int p = 0; p < 16; p++) begin
                for (int q = 0; q < 16; q++) begin
                    pend = (16'(1) << p) | (16'(1) << q);
                    cyc(1, 0);
                    chk("R3 pair winner", 32'(vec[3:0]), 32'(best(pend, m_top)));
                    cyc(0, 1);
                end
            end
        end

        // R5: nesting in fixed mode
        set_top(3);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                pend = 16'(1) << a;
                cyc(1, 0);
                pend = 16'(1) << b;
                #1;
                chk("R5 nest irq", 32'(irq), 32'(lvl(b, 3) < lvl(a, 3)));
                cyc(1, 0);
                look("R5 nest state");
                drain();
            end
        end

        // R2: masking
        set_top(0);
        pend = 16'hFFFF;
        for (int k = 0; k <= 16; k++) begin
            mask = (k == 16) ? 16'hFFFF : (16'(1) << k) - 16'd1;
            look("R2 mask");
            cyc(1, 0);
            look("R2 mask ack");
            drain();
        end
        pend = 16'h0100; mask = 16'h0100; #1;
        chk("R2 masked only", 32'(irq), 32'd0);
        mask = '0;

        // R10: acknowledge and return together
        pend = 16'h0020;
        cyc(1, 0);
        pend = 16'h0024;
        cyc(1, 1);
        chk("R10 isr", 32'(isr), 32'h0004);
        chk("R10 vec", 32'(vec[3:0]), 32'd2);
        look("R10 state");
        drain();

        // R11: software set and clear
        sw(16'h0001, 16'h0000);
        pend = 16'h0008;
        look("R11 set blocks");
        sw(16'h0001, 16'h0001);
        chk("R11 set wins", 32'(isr), 32'h0001);
        sw(16'h0000, 16'h0001);
        look("R11 clear");
        #1 chk("R11 irq back", 32'(irq), 32'd1);

        // R9: fixed mode completion keeps top
        set_top(2);
        sw(16'h0080, 16'h0000);
        sw(16'h0000, 16'h0080);
        pend = 16'hFFFF;
        cyc(1, 0);
        chk("R9 fixed no rotate", 32'(vec[3:0]), 32'd2);
        drain();

        // R6/R9: rotation sequence
        fixed = 0;
        set_top(0);
        for (int i = 0; i < 34; i++) begin
            cyc(1, 0);
            chk("R9 rotate order", 32'(vec[3:0]), 32'(i % 16));
            look("R6 blocked in service");
            cyc(0, 1);
        end
        sw(16'h0200, 16'h0000);
        sw(16'h0000, 16'h0200);
        cyc(1, 0);
        chk("R9 sw clear rotates", 32'(vec[3:0]), 32'd10);
        look("R9 state");
        cyc(0, 1);

        // R4: top write in rotation mode
        set_top(12);
        cyc(1, 0);
        chk("R4 top write", 32'(vec[3:0]), 32'd12);
        // R4 precedence over rotation on the same edge
        twe = 1; tval = 4'd5;
        cyc(0, 1);
        m_top = 5;
        twe = 0;
        cyc(1, 0);
        chk("R4 write beats rotate", 32'(vec[3:0]), 32'd5);
        drain();
        look("R4 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule